// File: doc/BRIEF.md
# Ethernet receive frame event classifier

This block sits downstream of an Ethernet receive MAC and turns a per-frame summary into host-facing decisions. The summary is a byte count, a CRC-good flag and a one-cycle end-of-frame strobe. For each frame the block decides four things:

- whether the frame is dropped outright;
- which error and status events fire;
- whether the frame is handed over by DMA or by programmed I/O;
- how many bytes the host will find stored.

A 16-bit configuration register, written by the host, holds the event enables, the delivery mode, the CRC-retention choice and a gated streaming flag. Its low six bits read back as a fixed identifier. A one-shot skip command in the same register asks the buffer logic to delete the most recently committed frame.

Results come out one cycle after the end-of-frame strobe:

- event pulses, each one cycle long;
- a 16-bit status word that holds until the next frame, with the event bits in its upper ten bits and a fixed identifier in its low six bits;
- the stored length.

Top module: `rx_frame_classifier`

## Requirements
- R1: After reset the configuration reads 0x0003, the status word reads 0x0004, and no event, discard, DMA, frame-valid or skip pulse is active.
- R2: Configuration bits [5:0] always read 000011 and ignore writes. Bit 15 and the skip bit 6 always read 0. The other fields are bit 7 stream, bit 8 OK enable, bit 9 DMA-only, bit 10 auto-DMA, bit 11 keep-CRC, bit 12 CRC-error enable, bit 13 runt enable and bit 14 extra-data enable.
- R3: A frame shorter than 8 bytes pulses discard_o and sets only status bit 11. frame_valid_o and every event stay low, and the stored length is 0, under any configuration.
- R4: With the runt enable set, a kept frame of 8 to 63 bytes pulses evt_runt_o and sets status bit 8.
- R5: With the extra-data enable set, a frame longer than 1518 bytes pulses evt_extra_o and sets status bit 9, whatever its CRC flag.
- R6: With the CRC-error enable set, a kept frame whose CRC flag is low pulses evt_crc_o and sets status bit 7.
- R7: With the OK enable set, a kept frame of 64 to 1518 bytes with a good CRC pulses evt_ok_o and sets status bit 6, but only when that frame is not delivered by DMA.
- R8: A kept frame goes by DMA (dma_o pulse, status bit 10) when DMA-only is set, or when auto-DMA is set and dma_ready_i is high with the end-of-frame strobe. DMA-only wins over auto-DMA.
- R9: The stored length equals the byte count when keep-CRC is set, and the byte count minus 4 when it is clear.
- R10: A write with bit 6 set pulses skip_o for one cycle after the write, unless the written value has DMA-only set. Each further skip needs a new write.
- R11: The stream bit is stored only when the same write sets DMA-only or auto-DMA; otherwise it reads back 0.
- R12: Frame results appear in the cycle after the end-of-frame strobe. The status word holds until the next frame, and its low six bits are 000100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 16 | Configuration write data |
| cfg_rdata_o | output | 16 | Configuration readback |
| skip_o | output | 1 | Delete-last-committed-frame pulse |
| eof_i | input | 1 | End-of-frame strobe |
| byte_cnt_i | input | LEN_W | Frame length in bytes including CRC |
| crc_ok_i | input | 1 | Frame CRC was good |
| dma_ready_i | input | 1 | Auto-DMA condition met |
| frame_valid_o | output | 1 | Kept-frame result pulse |
| discard_o | output | 1 | Dropped-frame pulse |
| dma_o | output | 1 | Frame goes by DMA |
| evt_ok_o | output | 1 | Receive-OK event |
| evt_crc_o | output | 1 | CRC-error event |
| evt_runt_o | output | 1 | Runt event |
| evt_extra_o | output | 1 | Extra-data event |
| status_o | output | 16 | Held status word |
| stored_len_o | output | LEN_W | Stored length |

## Verification
Configuration readback is combinational from the register, so it is sampled one cycle after the write strobe is taken. The skip pulse also belongs to that cycle and must be gone in the next one. Every frame result is registered once, so the bench drives the strobe on a falling edge, the rising edge captures it, and the monitor compares at the following falling edge. The driver queues an expected result as the strobe is applied, and the monitor pops one entry in exactly the cycle frame_valid_o or discard_o rises. In all other cycles it requires every event pulse to be low, which also holds for back-to-back frames.

// File: rtl/rx_cls_pkg.sv
package rx_cls_pkg;
  localparam int CFG_W = 16;
  localparam logic [5:0] CFG_ID  = 6'b000011;
  localparam logic [5:0] STAT_ID = 6'b000100;

  // configuration bit positions
  localparam int B_SKIP     = 6;
  localparam int B_STREAM   = 7;
  localparam int B_OK_EN    = 8;
  localparam int B_DMA_ONLY = 9;
  localparam int B_AUTO_DMA = 10;
  localparam int B_KEEP_CRC = 11;
  localparam int B_CRC_EN   = 12;
  localparam int B_RUNT_EN  = 13;
  localparam int B_EXTRA_EN = 14;

  // status bit positions
  localparam int S_OK    = 6;
  localparam int S_CRC   = 7;
  localparam int S_RUNT  = 8;
  localparam int S_EXTRA = 9;
  localparam int S_DMA   = 10;
  localparam int S_DISC  = 11;

  typedef struct packed {
    logic extra_en;
    logic runt_en;
    logic crc_en;
    logic keep_crc;
    logic auto_dma;
    logic dma_only;
    logic ok_en;
    logic stream;
  } cfg_t;
endpackage

// File: rtl/rx_cfg_reg.sv
module rx_cfg_reg
  import rx_cls_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  output cfg_t             cfg_o,
  output logic [CFG_W-1:0] rdata_o,
  output logic             skip_o
);
  cfg_t cfg_q;
  logic skip_q;
  logic stream_ok;

  assign stream_ok = wdata_i[B_DMA_ONLY] | wdata_i[B_AUTO_DMA];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      skip_q <= 1'b0;
    end else begin
      skip_q <= we_i & wdata_i[B_SKIP] & ~wdata_i[B_DMA_ONLY];
      if (we_i) begin
        cfg_q.stream   <= wdata_i[B_STREAM] & stream_ok;
        cfg_q.ok_en    <= wdata_i[B_OK_EN];
        cfg_q.dma_only <= wdata_i[B_DMA_ONLY];
        cfg_q.auto_dma <= wdata_i[B_AUTO_DMA];
        cfg_q.keep_crc <= wdata_i[B_KEEP_CRC];
        cfg_q.crc_en   <= wdata_i[B_CRC_EN];
        cfg_q.runt_en  <= wdata_i[B_RUNT_EN];
        cfg_q.extra_en <= wdata_i[B_EXTRA_EN];
      end
    end
  end

  always_comb begin
    rdata_o             = '0;
    rdata_o[5:0]        = CFG_ID;
    rdata_o[B_STREAM]   = cfg_q.stream;
    rdata_o[B_OK_EN]    = cfg_q.ok_en;
    rdata_o[B_DMA_ONLY] = cfg_q.dma_only;
    rdata_o[B_AUTO_DMA] = cfg_q.auto_dma;
    rdata_o[B_KEEP_CRC] = cfg_q.keep_crc;
    rdata_o[B_CRC_EN]   = cfg_q.crc_en;
    rdata_o[B_RUNT_EN]  = cfg_q.runt_en;
    rdata_o[B_EXTRA_EN] = cfg_q.extra_en;
  end

  assign cfg_o  = cfg_q;
  assign skip_o = skip_q;

  p_stream_gated_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_q.stream |-> (cfg_q.dma_only | cfg_q.auto_dma));
  p_skip_cause_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    skip_o |-> $past(we_i && wdata_i[B_SKIP] && !wdata_i[B_DMA_ONLY]));
endmodule

// File: rtl/rx_frame_decide.sv
module rx_frame_decide
  import rx_cls_pkg::*;
#(
  parameter int LEN_W     = 14,
  parameter int MIN_KEEP  = 8,
  parameter int MIN_GOOD  = 64,
  parameter int MAX_GOOD  = 1518,
  parameter int CRC_BYTES = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  cfg_t             cfg_i,
  input  logic             eof_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             crc_ok_i,
  input  logic             dma_ready_i,
  output logic             frame_valid_o,
  output logic             discard_o,
  output logic             dma_o,
  output logic             evt_ok_o,
  output logic             evt_crc_o,
  output logic             evt_runt_o,
  output logic             evt_extra_o,
  output logic [CFG_W-1:0] status_o,
  output logic [LEN_W-1:0] stored_len_o
);
  localparam logic [LEN_W-1:0] LIM_KEEP = LEN_W'(MIN_KEEP);
  localparam logic [LEN_W-1:0] LIM_MIN  = LEN_W'(MIN_GOOD);
  localparam logic [LEN_W-1:0] LIM_MAX  = LEN_W'(MAX_GOOD);
  localparam logic [LEN_W-1:0] CRC_LEN  = LEN_W'(CRC_BYTES);

  logic too_short, is_runt, is_long, use_dma;
  logic d_ok, d_crc, d_runt, d_extra;
  logic [CFG_W-1:0] stat_d;
  logic [LEN_W-1:0] len_d;

  always_comb begin
    too_short = len_i < LIM_KEEP;
    is_runt   = len_i < LIM_MIN;
    is_long   = len_i > LIM_MAX;
    // forced DMA overrides the conditional one
    use_dma   = cfg_i.dma_only | (cfg_i.auto_dma & dma_ready_i);
    d_runt    = cfg_i.runt_en & is_runt;
    d_extra   = cfg_i.extra_en & is_long;
    d_crc     = cfg_i.crc_en & ~crc_ok_i;
    d_ok      = cfg_i.ok_en & ~use_dma & crc_ok_i & ~is_runt & ~is_long;
    len_d     = cfg_i.keep_crc ? len_i : len_i - CRC_LEN;
    stat_d    = '0;
    stat_d[5:0] = STAT_ID;
    if (too_short) begin
      stat_d[S_DISC] = 1'b1;
      len_d          = '0;
    end else begin
      stat_d[S_OK]    = d_ok;
      stat_d[S_CRC]   = d_crc;
      stat_d[S_RUNT]  = d_runt;
      stat_d[S_EXTRA] = d_extra;
      stat_d[S_DMA]   = use_dma;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_valid_o <= 1'b0;
      discard_o     <= 1'b0;
      dma_o         <= 1'b0;
      evt_ok_o      <= 1'b0;
      evt_crc_o     <= 1'b0;
      evt_runt_o    <= 1'b0;
      evt_extra_o   <= 1'b0;
      status_o      <= {{(CFG_W-6){1'b0}}, STAT_ID};
      stored_len_o  <= '0;
    end else begin
      frame_valid_o <= eof_i & ~too_short;
      discard_o     <= eof_i & too_short;
      dma_o         <= eof_i & ~too_short & use_dma;
      evt_ok_o      <= eof_i & ~too_short & d_ok;
      evt_crc_o     <= eof_i & ~too_short & d_crc;
      evt_runt_o    <= eof_i & ~too_short & d_runt;
      evt_extra_o   <= eof_i & ~too_short & d_extra;
      if (eof_i) begin
        status_o     <= stat_d;
        stored_len_o <= len_d;
      end
    end
  end

  p_discard_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    discard_o |-> !(frame_valid_o | evt_ok_o | evt_crc_o | evt_runt_o | evt_extra_o | dma_o));
  p_ok_not_dma_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_ok_o |-> !dma_o);
  p_after_eof_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_valid_o | discard_o) |-> $past(eof_i));
  p_status_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(eof_i) |-> $stable(status_o));
endmodule

// File: rtl/rx_frame_classifier.sv
module rx_frame_classifier
  import rx_cls_pkg::*;
#(
  parameter int LEN_W     = 14,
  parameter int MIN_KEEP  = 8,
  parameter int MIN_GOOD  = 64,
  parameter int MAX_GOOD  = 1518,
  parameter int CRC_BYTES = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [15:0]      cfg_wdata_i,
  output logic [15:0]      cfg_rdata_o,
  output logic             skip_o,
  input  logic             eof_i,
  input  logic [LEN_W-1:0] byte_cnt_i,
  input  logic             crc_ok_i,
  input  logic             dma_ready_i,
  output logic             frame_valid_o,
  output logic             discard_o,
  output logic             dma_o,
  output logic             evt_ok_o,
  output logic             evt_crc_o,
  output logic             evt_runt_o,
  output logic             evt_extra_o,
  output logic [15:0]      status_o,
  output logic [LEN_W-1:0] stored_len_o
);
  cfg_t cfg;

  rx_cfg_reg u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .cfg_o   (cfg),
    .rdata_o (cfg_rdata_o),
    .skip_o  (skip_o)
  );

  rx_frame_decide #(
    .LEN_W(LEN_W), .MIN_KEEP(MIN_KEEP), .MIN_GOOD(MIN_GOOD),
    .MAX_GOOD(MAX_GOOD), .CRC_BYTES(CRC_BYTES)
  ) u_decide (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .cfg_i         (cfg),
    .eof_i         (eof_i),
    .len_i         (byte_cnt_i),
    .crc_ok_i      (crc_ok_i),
    .dma_ready_i   (dma_ready_i),
    .frame_valid_o (frame_valid_o),
    .discard_o     (discard_o),
    .dma_o         (dma_o),
    .evt_ok_o      (evt_ok_o),
    .evt_crc_o     (evt_crc_o),
    .evt_runt_o    (evt_runt_o),
    .evt_extra_o   (evt_extra_o),
    .status_o      (status_o),
    .stored_len_o  (stored_len_o)
  );
endmodule

// File: tb/rx_frame_classifier_bench.sv
module rx_frame_classifier_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LW = 14;

  logic clk = 0, rst_ni = 0;
  logic cfg_we = 0;
  logic [15:0] cfg_wdata = '0, cfg_rdata;
  logic skip, eof = 0, crc_ok = 0, dma_ready = 0;
  logic [LW-1:0] byte_cnt = '0;
  logic fv, disc, dma, e_ok, e_crc, e_runt, e_extra;
  logic [15:0] status;
  logic [LW-1:0] slen;

  int n_run = 0, n_fail = 0;
  logic [15:0] m_cfg = 16'h0003;
  logic [15+LW:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_frame_classifier u_rx_frame_classifier (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata),
    .cfg_rdata_o(cfg_rdata), .skip_o(skip), .eof_i(eof), .byte_cnt_i(byte_cnt),
    .crc_ok_i(crc_ok), .dma_ready_i(dma_ready), .frame_valid_o(fv),
    .discard_o(disc), .dma_o(dma), .evt_ok_o(e_ok), .evt_crc_o(e_crc),
    .evt_runt_o(e_runt), .evt_extra_o(e_extra), .status_o(status),
    .stored_len_o(slen));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15+LW:0] model(input logic [15:0] m, input int len, input bit c, input bit r);
    logic [15:0] st;
    logic [LW-1:0] sl;
    bit d, rn, ex, ce, ok;
    if (len < 8) return {16'h0804, {LW{1'b0}}};
    d  = m[9] | (m[10] & r);
    rn = m[13] & (len < 64);
    ex = m[14] & (len > 1518);
    ce = m[12] & !c;
    ok = m[8] & !d & c & (len >= 64) & (len <= 1518);
    st = {4'b0, 1'b0, d, ex, rn, ce, ok, 6'b000100};
    sl = m[11] ? LW'(len) : LW'(len - 4);
    return {st, sl};
  endfunction

  // monitor
  always @(negedge clk) begin
    if (rst_ni) begin
      if (fv || disc) begin
        if (exp_q.size() == 0) chk(0, "R12 unexpected result", 32'(status), 0);
        else begin
          logic [15+LW:0] e;
          e = exp_q.pop_front();
          chk(status == e[15+LW:LW], "R12 status word", 32'(status), 32'(e[15+LW:LW]));
          chk(slen == e[LW-1:0], "R9 stored length", 32'(slen), 32'(e[LW-1:0]));
          chk(disc == e[LW+11], "R3 discard pulse", 32'(disc), 32'(e[LW+11]));
          chk(dma == e[LW+10], "R8 dma pulse", 32'(dma), 32'(e[LW+10]));
          chk(e_extra == e[LW+9], "R5 extra pulse", 32'(e_extra), 32'(e[LW+9]));
          chk(e_runt == e[LW+8], "R4 runt pulse", 32'(e_runt), 32'(e[LW+8]));
          chk(e_crc == e[LW+7], "R6 crc pulse", 32'(e_crc), 32'(e[LW+7]));
          chk(e_ok == e[LW+6], "R7 ok pulse", 32'(e_ok), 32'(e[LW+6]));
        end
      end else if (dma || e_ok || e_crc || e_runt || e_extra)
        chk(0, "R12 stray event", {27'b0, dma, e_ok, e_crc, e_runt, e_extra}, 0);
    end
  end

  task automatic wr(input logic [15:0] d, input logic [15:0] exp_rd, input bit exp_skip);
    @(negedge clk);
    cfg_we = 1; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
    chk(cfg_rdata == exp_rd, "R2 R11 readback", 32'(cfg_rdata), 32'(exp_rd));
    chk(skip == exp_skip, "R10 skip pulse", 32'(skip), 32'(exp_skip));
    m_cfg = exp_rd;
    @(negedge clk);
    chk(skip == 0, "R10 skip once", 32'(skip), 0);
  endtask

  task automatic frm(input int len, input bit c, input bit r);
    @(negedge clk);
    eof = 1; byte_cnt = LW'(len); crc_ok = c; dma_ready = r;
    exp_q.push_back(model(m_cfg, len, c, r));
  endtask

  task automatic idle();
    @(negedge clk);
    eof = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    chk(0, "watchdog", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cfg_rdata == 16'h0003, "R1 cfg reset", 32'(cfg_rdata), 32'h3);
    chk(status == 16'h0004, "R1 status reset", 32'(status), 32'h4);
    chk({fv, disc, dma, e_ok, e_crc, e_runt, e_extra, skip} == 0, "R1 pulses idle",
        {24'b0, fv, disc, dma, e_ok, e_crc, e_runt, e_extra, skip}, 0);
    rst_ni = 1;
    // R2 id bits fixed, bit15 and skip read 0; R10 skip ignored under dma-only
    wr(16'hFFFF, 16'h7F83, 0);
    // R11 stream blocked without a dma mode
    wr(16'h0080, 16'h0003, 0);
    // R10 skip with auto-dma
    wr(16'h0440, 16'h0403, 1);
    wr(16'h0240, 16'h0203, 0);
    wr(16'h0040, 16'h0003, 1);
    // all enables, CRC dropped
    wr(16'h7100, 16'h7103, 0);
    frm(7, 1, 0); idle();        // R3
    frm(8, 1, 0); idle();        // R4 lower bound
    frm(63, 1, 0); idle();       // R4 upper bound
    frm(64, 1, 0); idle();       // R7
    frm(1518, 1, 0); idle();     // R7 upper
    frm(1519, 0, 0); idle();     // R5 with bad CRC
    frm(1600, 1, 0); idle();     // R5 good CRC
    frm(200, 0, 0); idle();      // R6
    // back-to-back frames R12
    frm(100, 1, 0); frm(3, 1, 0); frm(30, 0, 0); idle();
    // R9 keep CRC
    wr(16'h7900, 16'h7903, 0);
    frm(100, 1, 0); idle();
    // R8 auto-dma
    wr(16'h7500, 16'h7503, 0);
    frm(300, 1, 1); idle();
    frm(300, 1, 0); idle();
    // R8 dma-only wins, R11 stream accepted
    wr(16'h7780, 16'h7783, 0);
    frm(300, 1, 0); idle();
    frm(5, 0, 1); idle();        // R3 under dma-only
    // enables off
    wr(16'h0000, 16'h0003, 0);
    frm(20, 0, 0); idle();
    frm(2000, 0, 0); idle();
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R12 all results seen", exp_q.size(), 0);
    chk(status == 16'h0004 && !fv, "R12 status held", 32'(status), 32'h4);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule